// File: doc/BRIEF.md
# Command Stream Decoder

This block walks a command list held in memory and converts it into a series of register writes for downstream engines. Software supplies a byte start address and a length counted in 32-bit words, then pulses `start`. The block reads the list one word at a time through a simple request/response memory port. It treats each word as either a header or an argument that belongs to the header before it.

Each header names a target register (the method), a subchannel and a submission mode. The mode decides how the argument words map onto methods. In one mode the method steps up by one for each argument. In another every argument goes to the same method. In a third the first argument goes to the method and every later one goes to the method plus one. A fourth mode carries a 13-bit immediate inside the header itself. Each resulting write leaves the block on a valid/ready port as a method, a subchannel and a 32-bit value.

When the list is used up and the last write has been accepted, the block raises `done` for one cycle. Malformed headers and lists that end too early set a sticky error flag. That flag clears at the next accepted start.

Top module: `cmd_stream_decoder`

## Requirements
- R1: A header packs the method in bits 12:0, the subchannel in bits 15:13, the count or immediate in bits 28:16 and the mode in bits 31:29. In modes 0 and 1, argument k (counting from 0) is written to method+k on the header's subchannel, with the method wrapping modulo 2^13.
- R2: In modes 2 and 3, every argument of the header is written to the header's method unchanged.
- R3: In mode 4, one write is emitted whose value is bits 28:16 of the header, zero-extended to 32 bits. No argument word is consumed.
- R4: In mode 5, the first argument goes to method and every later argument goes to method+1.
- R5: A header in modes 0 to 3 whose count is zero emits no write, and the next word is treated as a header.
- R6: A header with mode 6 or 7 sets the error flag and is skipped; decoding continues with the following word, and the flag stays set until the next accepted start.
- R7: A mode 5 header with a count of zero sets the error flag and is skipped without consuming argument words.
- R8: The block reads exactly the words from start address up to start address + 4 × length, each once. A zero-length list issues no read and still completes.
- R9: While the write port holds a write with ready low, its method, subchannel and value stay stable and no further memory read is issued once the internal one-word buffers are full.
- R10: `done` is high for exactly one cycle, after the last write of the list has been accepted. The write port is idle in that cycle.
- R11: An accepted start clears the error flag. A list that ends while a header still expects arguments sets the error flag and completes.
- R12: After reset, `wr_valid`, `done`, `err` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a list; ignored while a list is in progress |
| start_addr | input | ADDR_W | Byte address of the first word, word aligned |
| len_words | input | LEN_W | Number of 32-bit words in the list |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid for the outstanding request |
| mem_rdata | input | 32 | Read data |
| wr_valid | output | 1 | Register write available |
| wr_ready | input | 1 | Downstream accepts the write |
| wr_method | output | 13 | Target method of the write |
| wr_subch | output | 3 | Subchannel of the write |
| wr_data | output | 32 | Value of the write |
| done | output | 1 | One-cycle pulse when the list is finished |
| err | output | 1 | Sticky malformed-list flag |

## Verification
The assertions assume that the memory asserts `mem_rvalid` only once per request, and only after that request has been issued. The bench memory model answers every request exactly two cycles later and never answers unprompted. They also assume that `start` only arrives while the block is idle, or that it is ignored otherwise. The bench pulses `start` only after the previous `done` has been seen. Downstream backpressure is applied in a held-low phase and then in a toggling phase, so that the hold-stable property is exercised across many stalled cycles.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

    localparam int METH_W = 13;
    localparam int SUB_W  = 3;
    localparam int CNT_W  = 13;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        MD_STEP_A = 3'd0,
        MD_STEP_B = 3'd1,
        MD_SAME_A = 3'd2,
        MD_SAME_B = 3'd3,
        MD_IMM    = 3'd4,
        MD_ONCE   = 3'd5,
        MD_BAD_6  = 3'd6,
        MD_BAD_7  = 3'd7
    } mode_e;

    typedef struct packed {
        mode_e              mode;
        logic [CNT_W-1:0]   cnt;
        logic [SUB_W-1:0]   sub;
        logic [METH_W-1:0]  meth;
    } hdr_t;

    typedef struct packed {
        logic [METH_W-1:0]  meth;
        logic [SUB_W-1:0]   sub;
        logic [WORD_W-1:0]  data;
    } wr_evt_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HDR  = 2'd1,
        PH_ARG  = 2'd2
    } phase_e;

endpackage

// File: rtl/pbd_fetch.sv
module pbd_fetch #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go,
    input  logic [ADDR_W-1:0]         base_addr,
    input  logic [LEN_W-1:0]          n_words,
    output logic                      mem_req,
    output logic [ADDR_W-1:0]         mem_addr,
    input  logic                      mem_rvalid,
    input  logic [pbd_pkg::WORD_W-1:0] mem_rdata,
    input  logic                      take,
    output logic                      word_valid,
    output logic [pbd_pkg::WORD_W-1:0] word_data,
    output logic                      drained
);
    import pbd_pkg::*;

    localparam int STEP = WORD_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] lim;
        logic              pend;
        logic              held;
        logic [WORD_W-1:0] word;
    } fst_t;

    fst_t q, d;
    logic req_c;

    always_comb begin
        d     = q;
        req_c = 1'b0;
        if (go) begin
            d.ptr  = base_addr;
            d.lim  = base_addr + ADDR_W'({n_words, 2'b00});
            d.pend = 1'b0;
            d.held = 1'b0;
        end else begin
            if (take) begin
                d.held = 1'b0;
            end
            if (mem_rvalid && q.pend) begin
                d.pend = 1'b0;
                d.held = 1'b1;
                d.word = mem_rdata;
                d.ptr  = q.ptr + ADDR_W'(STEP);
            end
            if (!q.pend && !q.held && (q.ptr < q.lim)) begin
                req_c  = 1'b1;
                d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_req    = req_c;
    assign mem_addr   = q.ptr;
    assign word_valid = q.held;
    assign word_data  = q.word;
    assign drained    = !q.pend && !q.held && (q.ptr >= q.lim);

    AST_REQ_INSIDE_LIST: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr < q.lim)) else $error("read past list end"); // R8

    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (q.held && !take && !go) |=> $stable(q.ptr) && !mem_req) else $error("pointer moved while stalled"); // R9

endmodule

// File: rtl/pbd_parse.sv
module pbd_parse (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        go,
    input  logic                        word_valid,
    input  logic [pbd_pkg::WORD_W-1:0]  word_data,
    input  logic                        drained,
    input  logic                        slot_ready,
    input  logic                        out_idle,
    output logic                        take,
    output logic                        emit_valid,
    output pbd_pkg::wr_evt_t            emit_evt,
    output logic                        finish,
    output logic                        idle,
    output logic                        err
);
    import pbd_pkg::*;

    typedef struct packed {
        phase_e            ph;
        mode_e             mode;
        logic [METH_W-1:0] meth;
        logic [SUB_W-1:0]  sub;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  idx;
        logic              err;
    } pst_t;

    pst_t q, d;
    hdr_t h;
    logic [METH_W-1:0] arg_meth;

    always_comb begin
        unique case (q.mode)
            MD_STEP_A, MD_STEP_B: arg_meth = q.meth + q.idx;
            MD_ONCE:              arg_meth = q.meth + METH_W'(q.idx != '0);
            default:              arg_meth = q.meth;
        endcase
    end

    always_comb begin
        d          = q;
        h          = hdr_t'(word_data);
        take       = 1'b0;
        emit_valid = 1'b0;
        emit_evt   = '0;
        finish     = 1'b0;
        unique case (q.ph)
            PH_IDLE: begin
                if (go) begin
                    d.ph  = PH_HDR;
                    d.err = 1'b0;
                end
            end
            PH_HDR: begin
                if (word_valid) begin
                    unique case (h.mode)
                        MD_STEP_A, MD_STEP_B, MD_SAME_A, MD_SAME_B, MD_ONCE: begin
                            take = 1'b1;
                            if (h.cnt == '0) begin
                                if (h.mode == MD_ONCE) begin
                                    d.err = 1'b1;
                                end
                            end else begin
                                d.ph   = PH_ARG;
                                d.mode = h.mode;
                                d.meth = h.meth;
                                d.sub  = h.sub;
                                d.cnt  = h.cnt;
                                d.idx  = '0;
                            end
                        end
                        MD_IMM: begin
                            if (slot_ready) begin
                                take          = 1'b1;
                                emit_valid    = 1'b1;
                                emit_evt.meth = h.meth;
                                emit_evt.sub  = h.sub;
                                emit_evt.data = WORD_W'(h.cnt);
                            end
                        end
                        default: begin
                            take  = 1'b1;
                            d.err = 1'b1;
                        end
                    endcase
                end else if (drained && out_idle) begin
                    finish = 1'b1;
                    d.ph   = PH_IDLE;
                end
            end
            PH_ARG: begin
                if (word_valid) begin
                    if (slot_ready) begin
                        take          = 1'b1;
                        emit_valid    = 1'b1;
                        emit_evt.meth = arg_meth;
                        emit_evt.sub  = q.sub;
                        emit_evt.data = word_data;
                        d.idx         = q.idx + CNT_W'(1);
                        if ((q.idx + CNT_W'(1)) == q.cnt) begin
                            d.ph = PH_HDR;
                        end
                    end
                end else if (drained && out_idle) begin
                    d.err  = 1'b1;
                    finish = 1'b1;
                    d.ph   = PH_IDLE;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign idle = (q.ph == PH_IDLE);
    assign err  = q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.err && !go) |=> q.err) else $error("error flag dropped"); // R6

    AST_EMIT_HAS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        emit_valid |-> slot_ready) else $error("emit into full slot"); // R9

    AST_ARG_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> word_valid) else $error("consumed a missing word"); // R8

    AST_ONCE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_valid && q.ph == PH_ARG && q.mode == MD_ONCE && q.idx != '0)
            |-> (emit_evt.meth == q.meth + METH_W'(1))) else $error("once-mode target wrong"); // R4

endmodule

// File: rtl/pbd_out.sv
module pbd_out (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  pbd_pkg::wr_evt_t in_evt,
    output logic             in_ready,
    output logic             out_valid,
    output pbd_pkg::wr_evt_t out_evt,
    input  logic             out_ready
);
    import pbd_pkg::*;

    typedef struct packed {
        logic    valid;
        wr_evt_t evt;
    } ost_t;

    ost_t q, d;

    always_comb begin
        d        = q;
        in_ready = !q.valid || out_ready;
        if (out_ready) begin
            d.valid = 1'b0;
        end
        if (in_valid && in_ready) begin
            d.valid = 1'b1;
            d.evt   = in_evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.valid;
    assign out_evt   = q.evt;

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_evt))) else $error("stalled write changed"); // R9

endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  len_words,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [12:0]       wr_method,
    output logic [2:0]        wr_subch,
    output logic [31:0]       wr_data,
    output logic              done,
    output logic              err
);
    import pbd_pkg::*;

    logic    go, p_idle, take, word_valid, drained;
    logic    emit_valid, slot_ready, finish;
    logic [WORD_W-1:0] word_data;
    wr_evt_t emit_evt, out_evt;
    logic    done_d, done_q;

    assign go = start && p_idle;

    pbd_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .base_addr  (start_addr),
        .n_words    (len_words),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .take       (take),
        .word_valid (word_valid),
        .word_data  (word_data),
        .drained    (drained)
    );

    pbd_parse u_parse (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .word_valid (word_valid),
        .word_data  (word_data),
        .drained    (drained),
        .slot_ready (slot_ready),
        .out_idle   (!wr_valid),
        .take       (take),
        .emit_valid (emit_valid),
        .emit_evt   (emit_evt),
        .finish     (finish),
        .idle       (p_idle),
        .err        (err)
    );

    pbd_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (emit_valid),
        .in_evt    (emit_evt),
        .in_ready  (slot_ready),
        .out_valid (wr_valid),
        .out_evt   (out_evt),
        .out_ready (wr_ready)
    );

    always_comb begin
        done_d = finish;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= done_d;
        end
    end

    assign done      = done_q;
    assign wr_method = out_evt.meth;
    assign wr_subch  = out_evt.sub;
    assign wr_data   = out_evt.data;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R10

    AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_valid) else $error("done with write pending"); // R10

endmodule

// File: tb/sim_cmd_stream_decoder.sv
`timescale 1ns/1ps
module sim_cmd_stream_decoder;

    function automatic logic [31:0] mkh(int md, int cnt, int sb, int mt);
        logic [2:0] m3; logic [12:0] c13; logic [2:0] s3; logic [12:0] t13;
        m3 = md[2:0]; c13 = cnt[12:0]; s3 = sb[2:0]; t13 = mt[12:0];
        return {m3, c13, s3, t13};
    endfunction

    localparam int NA = 18;
    localparam int NE = 12;
    localparam logic [31:0] IMG_A [NA] = '{
        mkh(1, 3, 2, 'h100), 32'hA000_0000, 32'hA000_0001, 32'hA000_0002,
        mkh(3, 2, 1, 'h200), 32'hB000_0010, 32'hB000_0011,
        mkh(4, 'h1ABC, 5, 'h040),
        mkh(5, 3, 7, 'h300), 32'hC000_0020, 32'hC000_0021, 32'hC000_0022,
        mkh(0, 0, 3, 'h050),
        mkh(2, 1, 0, 'h1FFF), 32'hD000_0030,
        mkh(0, 2, 4, 'h1FFF), 32'hE000_0040, 32'hE000_0041
    };
    localparam logic [47:0] EXP_A [NE] = '{
        {13'h100, 3'd2, 32'hA000_0000}, {13'h101, 3'd2, 32'hA000_0001},
        {13'h102, 3'd2, 32'hA000_0002}, {13'h200, 3'd1, 32'hB000_0010},
        {13'h200, 3'd1, 32'hB000_0011}, {13'h040, 3'd5, 32'h0000_1ABC},
        {13'h300, 3'd7, 32'hC000_0020}, {13'h301, 3'd7, 32'hC000_0021},
        {13'h301, 3'd7, 32'hC000_0022}, {13'h1FFF, 3'd0, 32'hD000_0030},
        {13'h1FFF, 3'd4, 32'hE000_0040}, {13'h0000, 3'd4, 32'hE000_0041}
    };

    function automatic string tag_of(int i);
        case (i)
            3, 4, 9:  return "R2";
            5:        return "R3";
            6, 7, 8:  return "R4";
            default:  return "R1";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [15:0] len_words = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [12:0] wr_method;
    logic [2:0]  wr_subch;
    logic [31:0] wr_data;
    logic        done;
    logic        err;

    int checks = 0;
    int errors = 0;
    int rdy_mode = 0;
    int log_n = 0;
    int req_cnt = 0;
    int done_cnt = 0;
    int done_dbl = 0;
    logic done_prev = 1'b0;
    logic finished = 1'b0;
    logic [47:0] wlog [64];
    logic [31:0] mem [64];
    logic        p1_v;
    logic [31:0] p1_a;

    always #4 clk = ~clk;

    cmd_stream_decoder u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .len_words(len_words), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_method(wr_method), .wr_subch(wr_subch),
        .wr_data(wr_data), .done(done), .err(err)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p1_v <= 1'b0; p1_a <= '0; mem_rvalid <= 1'b0; mem_rdata <= '0;
        end else begin
            p1_v <= mem_req;
            p1_a <= mem_addr;
            mem_rvalid <= p1_v;
            mem_rdata <= mem[p1_a[7:2]];
        end
    end

    always @(posedge clk) begin
        #1;
        if (rdy_mode == 0) wr_ready = 1'b1;
        else if (rdy_mode == 1) wr_ready = 1'b0;
        else wr_ready = ~wr_ready;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid && wr_ready && log_n < 64) begin
                wlog[log_n] = {wr_method, wr_subch, wr_data};
                log_n++;
            end
            if (mem_req) req_cnt++;
            if (done) done_cnt++;
            if (done && done_prev) done_dbl++;
            done_prev = done;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        log_n = 0; req_cnt = 0; done_cnt = 0;
    endtask

    task automatic run_list(input logic [31:0] a, input logic [15:0] n);
        @(posedge clk); #1;
        start = 1'b1; start_addr = a; len_words = n;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int g = 0; g < 3000; g++) begin
            @(negedge clk);
            if (done) break;
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        for (int i = 0; i < NA; i++) mem[i] = IMG_A[i];
        mem[20] = mkh(6, 5, 0, 'h010);
        mem[21] = mkh(4, 7, 1, 'h011);
        mem[24] = mkh(5, 0, 0, 'h020);
        mem[25] = mkh(4, 3, 2, 'h021);
        mem[28] = mkh(1, 4, 0, 'h030);
        mem[29] = 32'h5A5A_0001;

        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!wr_valid, "R12 wr_valid", 64'(wr_valid), 0);
        chk(!done, "R12 done", 64'(done), 0);
        chk(!err, "R12 err", 64'(err), 0);
        chk(!mem_req, "R12 mem_req", 64'(mem_req), 0);
        #1 rst_n = 1'b1;

        // Vector table walk: list A with ready always high
        clear_counts();
        run_list(32'd0, 16'(NA));
        wait_done();
        chk(log_n == NE, "R1 write count", 64'(log_n), 64'(NE));
        for (int i = 0; i < NE; i++)
            chk(wlog[i] == EXP_A[i], tag_of(i), 64'(wlog[i]), 64'(EXP_A[i]));
        chk(req_cnt == NA, "R8 reads equal length (R3 R5 no extra words)", 64'(req_cnt), 64'(NA));
        chk(done_cnt == 1, "R10 one done", 64'(done_cnt), 1);
        chk(!err, "R5 no error on clean list", 64'(err), 0);

        // R6 reserved mode skipped, next header still decoded
        clear_counts();
        run_list(32'd80, 16'd2);
        wait_done();
        chk(err, "R6 err set", 64'(err), 1);
        chk(log_n == 1 && wlog[0] == {13'h011, 3'd1, 32'd7}, "R6 continue after skip", 64'(wlog[0]), {13'h011, 3'd1, 32'd7});

        // R7 once-mode zero count
        clear_counts();
        run_list(32'd96, 16'd2);
        wait_done();
        chk(err, "R7 err set", 64'(err), 1);
        chk(log_n == 1 && wlog[0] == {13'h021, 3'd2, 32'd3}, "R7 header skipped", 64'(wlog[0]), {13'h021, 3'd2, 32'd3});

        // R8 zero length, R11 error cleared by start
        clear_counts();
        run_list(32'd200, 16'd0);
        wait_done();
        chk(done_cnt == 1, "R8 empty list done", 64'(done_cnt), 1);
        chk(req_cnt == 0, "R8 empty list no reads", 64'(req_cnt), 0);
        chk(!err, "R11 err cleared", 64'(err), 0);

        // R11 truncated list
        clear_counts();
        run_list(32'd112, 16'd2);
        wait_done();
        chk(log_n == 1 && wlog[0] == {13'h030, 3'd0, 32'h5A5A_0001}, "R11 partial write", 64'(wlog[0]), {13'h030, 3'd0, 32'h5A5A_0001});
        chk(err, "R11 truncation error", 64'(err), 1);

        // R9 backpressure: hold ready low, then toggle
        clear_counts();
        rdy_mode = 1;
        run_list(32'd0, 16'(NA));
        repeat (12) @(negedge clk);
        req_cnt = 0;
        chk(wr_valid && {wr_method, wr_subch, wr_data} == EXP_A[0], "R9 first write held", 64'({wr_method, wr_subch, wr_data}), 64'(EXP_A[0]));
        repeat (20) @(negedge clk);
        chk(req_cnt == 0, "R9 no reads while stalled", 64'(req_cnt), 0);
        chk(wr_valid && {wr_method, wr_subch, wr_data} == EXP_A[0], "R9 write stable", 64'({wr_method, wr_subch, wr_data}), 64'(EXP_A[0]));
        chk(log_n == 0, "R9 nothing accepted", 64'(log_n), 0);
        rdy_mode = 2;
        wait_done();
        chk(log_n == NE, "R9 count under toggling", 64'(log_n), 64'(NE));
        for (int i = 0; i < NE; i++)
            chk(wlog[i] == EXP_A[i], "R9 order under toggling", 64'(wlog[i]), 64'(EXP_A[i]));
        chk(done_dbl == 0, "R10 done single cycle", 64'(done_dbl), 0);
        rdy_mode = 0;

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule